// File: doc/BRIEF.md
# Way-Predicting Set-Associative Read Cache

This block is a four-way set-associative read cache that tries to save array energy by guessing, for each set, which way a lookup will hit. A request's address splits into a tag, a set index and a word offset within the line. On the first cycle after a request is accepted, only the guessed way's tag and data arrays are enabled. When the guess is right the word is returned at once, and the access has cost a single tag read and a single data read.

When the guess is wrong, the remaining ways are probed in the following cycle and a hit there is returned one cycle later, flagged as a mispredict. If no way matches, the block asks memory for the whole line, installs it into a victim way and then returns the requested word. The per-set guess always follows the most recent way that hit or was filled. Three free-running counters expose how many lookups were guessed right, guessed wrong, or missed. Array enables are brought out as ports so the energy cost of each access can be observed.

Top module: `wpc_cache`

## Requirements
- R1: After reset no line is valid, every set's guess is way 0, all three counters read zero, `req_ready` is high and `rsp_valid`, `mem_req_valid`, `tag_rd_en` and `data_rd_en` are low.
- R2: In the cycle after a request is accepted, exactly one bit of `tag_rd_en` is set, bit i meaning way i. That bit is the set's guessed way, and `data_rd_en` equals `tag_rd_en`.
- R3: If the guessed way holds a valid matching tag, `rsp_valid` is high in the cycle after acceptance, with `rsp_hit`=1 and `rsp_mispredict`=0.
- R4: If the guess is wrong, the next cycle enables every way except the guessed one. A match there gives `rsp_valid` two cycles after acceptance, with `rsp_hit`=1 and `rsp_mispredict`=1.
- R5: After a mispredicted hit, the set's guess becomes the way that hit.
- R6: If no way matches, `mem_req_valid` rises in the cycle after the second probe and stays high, with a stable `mem_req_addr` equal to the request address without its offset bits, until `mem_rsp_valid` is seen. The cycle after that, `rsp_valid` is high with `rsp_hit`=0 and `rsp_mispredict`=0, and the set's guess becomes the filled way.
- R7: The fill victim is the lowest-numbered invalid way of the set; if all ways are valid, it is the way least recently hit or filled. In the response cycle of a fill, `data_rd_en` has only the victim's bit set.
- R8: `rsp_data` is the word selected by the offset bits of the address, where word w of a line sits at bits [w*DATA_W +: DATA_W] of `mem_rsp_line`.
- R9: `cnt_correct`, `cnt_mispred` and `cnt_miss` each add one for every first-probe hit, second-probe hit and full miss respectively, and wrap at their width.
- R10: `req_ready` is low from acceptance until the response cycle has passed. `rsp_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Word address of the lookup |
| rsp_valid | output | 1 | Response word valid this cycle |
| rsp_data | output | DATA_W | Returned word |
| rsp_hit | output | 1 | Response came from a cache hit |
| rsp_mispredict | output | 1 | Hit was found in the second probe |
| mem_req_valid | output | 1 | Line fill requested |
| mem_req_addr | output | ADDR_W-log2(LINE_WORDS) | Line address to fetch |
| mem_rsp_valid | input | 1 | Fill line present |
| mem_rsp_line | input | DATA_W*LINE_WORDS | Fill line contents |
| tag_rd_en | output | WAYS | Tag array read enable per way |
| data_rd_en | output | WAYS | Data array read enable per way |
| cnt_correct | output | CNT_W | Correct-guess count |
| cnt_mispred | output | CNT_W | Wrong-guess hit count |
| cnt_miss | output | CNT_W | Full-miss count |

## Verification
The bench mixes a directed opening with a long pseudo-random sweep. The sweep runs over four sets, six competing tags and both offsets, with varying memory latency, so sets are filled, overfilled and thrashed many times. A design that enabled all ways on the first probe, or kept a stale guess after a second-probe hit, would show the wrong enable pattern on the next access to that set. A design with an off-by-one latency would respond in the wrong cycle. The first fill of a set must take the lowest invalid way, and later fills must evict the least recently touched way. A wrong victim choice shows up both in the fill cycle's data enable and as unexpected misses later on.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FIRST,
      ST_SECOND,
      ST_FILL,
      ST_DONE
   } wpc_state_e;
endpackage

// File: rtl/wpc_pred_table.sv
module wpc_pred_table #(
   parameter int SETS  = 4,
   parameter int WAY_W = 2,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [WAY_W-1:0] rd_way,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic [WAY_W-1:0] wr_way
);
   logic [WAY_W-1:0] guess_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) guess_q[s] <= '0;
      end else if (wr_en) begin
         guess_q[wr_set] <= wr_way;
      end
   end

   assign rd_way = guess_q[rd_set];
endmodule

// File: rtl/wpc_lru_ages.sv
module wpc_lru_ages #(
   parameter int SETS = 4,
   parameter int WAYS = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] oldest_way
);
   logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
   logic [WAY_W-1:0] touched_age;

   assign touched_age = age_q[set_idx][touch_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[set_idx][w] <= '0;
            else if (age_q[set_idx][w] < touched_age)
               age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
         end
      end
   end

   always_comb begin
      oldest_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (age_q[set_idx][w] == WAY_W'(WAYS-1)) oldest_way = WAY_W'(w);
   end
endmodule

// File: rtl/wpc_way_match.sv
module wpc_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0]            valid,
   input  logic [TAG_W-1:0]           lookup_tag,
   input  logic [WAYS-1:0]            enable,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit_any,
   output logic [WAY_W-1:0]           hit_way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = enable[w] & valid[w] & (tags[w] == lookup_tag);
   end

   assign hit_any = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end
endmodule

// File: rtl/wpc_way_mux.sv
module wpc_way_mux #(
   parameter int WAYS   = 4,
   parameter int LINE_W = 16
) (
   input  logic [WAYS-1:0][LINE_W-1:0] lines,
   input  logic [WAYS-1:0]             sel_oh,
   output logic [LINE_W-1:0]           line_out
);
   logic [WAYS-1:0][LINE_W-1:0] masked;

   for (genvar w = 0; w < WAYS; w++) begin : g_mask
      assign masked[w] = lines[w] & {LINE_W{sel_oh[w]}};
   end

   always_comb begin
      line_out = '0;
      for (int w = 0; w < WAYS; w++) line_out = line_out | masked[w];
   end
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
   import wpc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int SETS       = 4,
   parameter int WAYS       = 4,
   parameter int LINE_WORDS = 2,
   parameter int CNT_W      = 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   output logic                                   req_ready,
   input  logic [ADDR_W-1:0]                      req_addr,
   output logic                                   rsp_valid,
   output logic [DATA_W-1:0]                      rsp_data,
   output logic                                   rsp_hit,
   output logic                                   rsp_mispredict,
   output logic                                   mem_req_valid,
   output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]   mem_req_addr,
   input  logic                                   mem_rsp_valid,
   input  logic [DATA_W*LINE_WORDS-1:0]           mem_rsp_line,
   output logic [WAYS-1:0]                        tag_rd_en,
   output logic [WAYS-1:0]                        data_rd_en,
   output logic [CNT_W-1:0]                       cnt_correct,
   output logic [CNT_W-1:0]                       cnt_mispred,
   output logic [CNT_W-1:0]                       cnt_miss
);
   localparam int OFF_W  = $clog2(LINE_WORDS);
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
   localparam int LINE_W = DATA_W * LINE_WORDS;

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("wpc_cache: WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("wpc_cache: SETS must be a power of two, at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("wpc_cache: LINE_WORDS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wpc_cache: ADDR_W too small for SETS and LINE_WORDS");
   end

   wpc_state_e state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SET_W-1:0]  set_s;
   logic [TAG_W-1:0]  tag_s;
   logic [OFF_W-1:0]  off_s;

   logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
   logic [WAYS-1:0][LINE_W-1:0] line_q [SETS];
   logic [WAYS-1:0]             vld_q  [SETS];

   logic [WAY_W-1:0] guess_way, lru_way, vic_way, hit_way, upd_way;
   logic [WAYS-1:0]  guess_oh, hit_vec, sel_oh;
   logic             hit_any, fill_we, upd_en, touch_en;
   logic [WAY_W-1:0] touch_way;
   logic [LINE_W-1:0] sel_line;

   assign set_s    = addr_q[OFF_W +: SET_W];
   assign tag_s    = addr_q[ADDR_W-1 -: TAG_W];
   assign off_s    = addr_q[OFF_W-1:0];
   assign guess_oh = WAYS'(1) << guess_way;

   // Array enables: the guessed way alone first, the rest on a wrong guess.
   always_comb begin
      tag_rd_en  = '0;
      data_rd_en = '0;
      case (state_q)
         ST_FIRST:  begin tag_rd_en = guess_oh;  data_rd_en = guess_oh;  end
         ST_SECOND: begin tag_rd_en = ~guess_oh; data_rd_en = ~guess_oh; end
         ST_DONE:   data_rd_en = guess_oh;
         default:   ;
      endcase
   end

   wpc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .tags(tag_q[set_s]), .valid(vld_q[set_s]), .lookup_tag(tag_s),
      .enable(tag_rd_en), .hit_vec(hit_vec), .hit_any(hit_any), .hit_way(hit_way)
   );

   assign sel_oh = (state_q == ST_DONE) ? guess_oh : hit_vec;

   wpc_way_mux #(.WAYS(WAYS), .LINE_W(LINE_W)) u_mux (
      .lines(line_q[set_s]), .sel_oh(sel_oh), .line_out(sel_line)
   );

   always_comb begin
      vic_way = lru_way;
      for (int w = WAYS - 1; w >= 0; w--)
         if (!vld_q[set_s][w]) vic_way = WAY_W'(w);
   end

   assign fill_we   = (state_q == ST_FILL) && mem_rsp_valid;
   assign upd_en    = ((state_q == ST_SECOND) && hit_any) || fill_we;
   assign upd_way   = fill_we ? vic_way : hit_way;
   assign touch_en  = (((state_q == ST_FIRST) || (state_q == ST_SECOND)) && hit_any) || fill_we;
   assign touch_way = upd_way;

   wpc_pred_table #(.SETS(SETS), .WAY_W(WAY_W)) u_pred (
      .clk(clk), .rst_n(rst_n), .rd_set(set_s), .rd_way(guess_way),
      .wr_en(upd_en), .wr_set(set_s), .wr_way(upd_way)
   );

   wpc_lru_ages #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n), .set_idx(set_s), .touch_en(touch_en),
      .touch_way(touch_way), .oldest_way(lru_way)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         cnt_correct <= '0;
         cnt_mispred <= '0;
         cnt_miss    <= '0;
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               state_q <= ST_FIRST;
            end
            ST_FIRST: begin
               if (hit_any) begin
                  cnt_correct <= cnt_correct + 1'b1;
                  state_q     <= ST_IDLE;
               end else begin
                  state_q <= ST_SECOND;
               end
            end
            ST_SECOND: begin
               if (hit_any) begin
                  cnt_mispred <= cnt_mispred + 1'b1;
                  state_q     <= ST_IDLE;
               end else begin
                  cnt_miss <= cnt_miss + 1'b1;
                  state_q  <= ST_FILL;
               end
            end
            ST_FILL: if (mem_rsp_valid) begin
               vld_q[set_s][vic_way] <= 1'b1;
               state_q               <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         tag_q[set_s][vic_way]  <= tag_s;
         line_q[set_s][vic_way] <= mem_rsp_line;
      end
   end

   assign req_ready      = (state_q == ST_IDLE);
   assign rsp_valid      = (((state_q == ST_FIRST) || (state_q == ST_SECOND)) && hit_any)
                           || (state_q == ST_DONE);
   assign rsp_hit        = rsp_valid && (state_q != ST_DONE);
   assign rsp_mispredict = rsp_valid && (state_q == ST_SECOND);
   assign rsp_data       = sel_line[off_s*DATA_W +: DATA_W];
   assign mem_req_valid  = (state_q == ST_FILL);
   assign mem_req_addr   = addr_q[ADDR_W-1:OFF_W];
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
   parameter int WAYS  = 4,
   parameter int CNT_W = 16,
   parameter int MA_W  = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic             rsp_mispredict,
   input logic             mem_req_valid,
   input logic [MA_W-1:0]  mem_req_addr,
   input logic             mem_rsp_valid,
   input logic [WAYS-1:0]  tag_rd_en,
   input logic [WAYS-1:0]  data_rd_en,
   input logic [CNT_W-1:0] cnt_correct
);
   p_one_probe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> ($countones(tag_rd_en) == 1 && data_rd_en == tag_rd_en));

   p_fast_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && !rsp_mispredict) |-> $past(req_valid && req_ready));

   p_second_probe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_mispredict) |-> (rsp_hit && $countones(tag_rd_en) == WAYS - 1));

   p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

   p_fill_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_rsp_valid) |=> (rsp_valid && !rsp_hit && !rsp_mispredict));

   p_cnt_correct_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && !rsp_mispredict) |=>
         (cnt_correct == CNT_W'($past(cnt_correct) + 1'b1)));

   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   p_rsp_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind wpc_cache wpc_checker #(
   .WAYS(WAYS), .CNT_W(CNT_W), .MA_W(ADDR_W - $clog2(LINE_WORDS))
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mispredict(rsp_mispredict),
   .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
   .mem_rsp_valid(mem_rsp_valid), .tag_rd_en(tag_rd_en), .data_rd_en(data_rd_en),
   .cnt_correct(cnt_correct)
);

// File: tb/tb_wpc_cache.sv
module tb_wpc_cache;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 12, DATA_W = 8, SETS = 4, WAYS = 4, LINE_WORDS = 2, CNT_W = 16;
   localparam int OFF_W = 1, SET_W = 2;
   localparam int LINE_W = DATA_W * LINE_WORDS;
   localparam int MA_W = ADDR_W - OFF_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic rsp_valid, rsp_hit, rsp_mispredict;
   logic [DATA_W-1:0] rsp_data;
   logic mem_req_valid;
   logic [MA_W-1:0] mem_req_addr;
   logic mem_rsp_valid = 1'b0;
   logic [LINE_W-1:0] mem_rsp_line = '0;
   logic [WAYS-1:0] tag_rd_en, data_rd_en;
   logic [CNT_W-1:0] cnt_correct, cnt_mispred, cnt_miss;

   int checks = 0, errors = 0;
   bit done = 0;

   int m_tag   [SETS][WAYS];
   bit m_vld   [SETS][WAYS];
   int m_stamp [SETS][WAYS];
   int m_pred  [SETS];
   int m_ok = 0, m_mis = 0, m_miss = 0, stamp = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wpc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WAYS(WAYS),
               .LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_hit(rsp_hit), .rsp_mispredict(rsp_mispredict),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
      .tag_rd_en(tag_rd_en), .data_rd_en(data_rd_en),
      .cnt_correct(cnt_correct), .cnt_mispred(cnt_mispred), .cnt_miss(cnt_miss)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [LINE_W-1:0] mk_line(input int la);
      logic [LINE_W-1:0] l;
      for (int w = 0; w < LINE_WORDS; w++)
         l[w*DATA_W +: DATA_W] = DATA_W'((la * LINE_WORDS + w) * 29 + 7);
      return l;
   endfunction

   task automatic chk_counters();
      chk("R9 correct count", 32'(cnt_correct), 32'(m_ok));
      chk("R9 mispredict count", 32'(cnt_mispred), 32'(m_mis));
      chk("R9 miss count", 32'(cnt_miss), 32'(m_miss));
   endtask

   // Starts and ends on a falling edge.
   task automatic access(input int addr, input int lat);
      int set, tag, pw, hw, vic, oldest;
      logic [DATA_W-1:0] exp_data;
      set = (addr >> OFF_W) % SETS;
      tag = addr >> (OFF_W + SET_W);
      exp_data = DATA_W'(addr * 29 + 7);
      pw = m_pred[set];
      hw = -1;
      for (int w = 0; w < WAYS; w++) if (m_vld[set][w] && m_tag[set][w] == tag) hw = w;

      chk("R10 ready while idle", 32'(req_ready), 1);
      req_valid = 1'b1;
      req_addr  = ADDR_W'(addr);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 busy after accept", 32'(req_ready), 0);
      chk("R2 first probe tag enable", 32'(tag_rd_en), 32'(1 << pw));
      chk("R2 first probe data enable", 32'(data_rd_en), 32'(1 << pw));
      stamp++;
      if (hw == pw) begin
         chk("R3 fast response valid", 32'(rsp_valid), 1);
         chk("R3 fast hit flags", {30'd0, rsp_hit, rsp_mispredict}, 32'b10);
         chk("R8 fast data", 32'(rsp_data), 32'(exp_data));
         m_ok++;
         m_stamp[set][pw] = stamp;
      end else begin
         chk("R3 no response on wrong guess", 32'(rsp_valid), 0);
         @(negedge clk);
         chk("R4 second probe enables", 32'(tag_rd_en), 32'(~(1 << pw) & ((1 << WAYS) - 1)));
         if (hw >= 0) begin
            chk("R4 second response valid", 32'(rsp_valid), 1);
            chk("R4 mispredict flags", {30'd0, rsp_hit, rsp_mispredict}, 32'b11);
            chk("R8 second data", 32'(rsp_data), 32'(exp_data));
            m_mis++;
            m_pred[set] = hw;
            m_stamp[set][hw] = stamp;
         end else begin
            chk("R6 no response before fill", 32'(rsp_valid), 0);
            m_miss++;
            vic = -1;
            for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[set][w]) vic = w;
            if (vic < 0) begin
               oldest = 0;
               for (int w = 1; w < WAYS; w++)
                  if (m_stamp[set][w] < m_stamp[set][oldest]) oldest = w;
               vic = oldest;
            end
            @(negedge clk);
            for (int c = 0; c < lat; c++) begin
               chk("R6 fill request held", 32'(mem_req_valid), 1);
               @(negedge clk);
            end
            chk("R6 fill request", 32'(mem_req_valid), 1);
            chk("R6 fill address", 32'(mem_req_addr), 32'(addr >> OFF_W));
            mem_rsp_valid = 1'b1;
            mem_rsp_line  = mk_line(addr >> OFF_W);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk("R6 fill response valid", 32'(rsp_valid), 1);
            chk("R6 fill flags", {30'd0, rsp_hit, rsp_mispredict}, 32'b00);
            chk("R8 fill data", 32'(rsp_data), 32'(exp_data));
            chk("R7 victim way", 32'(data_rd_en), 32'(1 << vic));
            m_vld[set][vic]   = 1'b1;
            m_tag[set][vic]   = tag;
            m_stamp[set][vic] = stamp;
            m_pred[set]       = vic;
         end
      end
      @(negedge clk);
      chk("R10 no back-to-back response", 32'(rsp_valid), 0);
   endtask

   initial begin
      int seed;
      for (int s = 0; s < SETS; s++) begin
         m_pred[s] = 0;
         for (int w = 0; w < WAYS; w++) begin
            m_vld[s][w] = 1'b0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", 32'(req_ready), 1);
      chk("R1 quiet outputs", {28'd0, rsp_valid, mem_req_valid, |tag_rd_en, |data_rd_en}, 0);
      chk_counters();

      // Directed: cold miss, correct guess, competing tag, wrong guess.
      access(12'h000, 0);   // R1 guess way 0, R7 lowest invalid way 0
      access(12'h000, 0);   // R3
      access(12'h001, 1);   // other word, same line: R8
      access(12'h008, 2);   // new tag set 0: miss into way 1
      access(12'h000, 0);   // R4 guess way 1, hit way 0
      access(12'h001, 0);   // R5 guess now way 0
      chk_counters();

      // Sweep: 4 sets, 6 tags, 2 offsets, varying memory latency.
      seed = 32'h1234;
      for (int i = 0; i < 600; i++) begin
         int t, s, o;
         seed = seed * 1103515245 + 12345;
         t = (seed >>> 16) & 32'hFFFF;
         s = t % SETS;
         o = (t >> 4) % LINE_WORDS;
         t = (t >> 8) % 6;
         access((t << (OFF_W + SET_W)) | (s << OFF_W) | o, i % 3);
         if (i % 100 == 99) chk_counters();
      end
      chk_counters();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule